// File: doc/BRIEF.md
# Bank Row Timing Guard

This block watches the row timing of a single DRAM bank inside a memory controller. The command scheduler presents the command it wants to send to the bank (open a row, read, read with automatic close, or close the row) on one of four request inputs. Each cycle the block reports whether a row close or a row open would be legal at the next clock edge, and the bank's current phase: idle, row open, or closing.

Two analog limits govern the bank. One is the minimum time a row must stay open before it may be closed. The other is the time a close takes before the bank can be opened again. Both are given in picoseconds together with the clock period, and each is turned into a whole number of cycles by rounding up. For a read with automatic close, the block works out the internal close point itself. That point is the end of the read burst minus the CAS latency, which is the same edge as the earliest explicit close that would not cut the burst short. If the minimum open time has not yet passed at that point, the close waits until it has.

A request that arrives while it is not allowed is ignored and raises a sticky violation flag, so that a controller under test can be caught breaking the rules.

Top module: `bank_row_guard`

## Requirements
- R1: During and after reset the phase output `bank_state` is IDLE (code 2'd0), `act_ok` is 1, `pre_ok` is 0 and `violation` is 0. The other phase codes are ACTIVE = 2'd1 and CLOSING = 2'd2.
- R2: The open-time and close-time limits become cycle counts by ceiling division of the picosecond value by `TCK_PS`. With the defaults this gives 9 cycles open and 4 cycles close.
- R3: When a close starts at edge p, explicit or automatic, `bank_state` is CLOSING after p and `act_ok` stays 0 until after edge p+TRP_CYC-1. An open request is accepted at edge p+TRP_CYC at the earliest. Without one the phase returns to IDLE after that edge.
- R4: After an open accepted at edge a, `pre_ok` stays 0 until after edge a+TRAS_CYC-1. A close is therefore accepted at edge a+TRAS_CYC at the earliest.
- R5: A plain read at edge r with the open time satisfied leaves `pre_ok` at 1. A close at edge r+1 is accepted and cuts the burst short.
- R6: A read with automatic close at edge r, with the open time already met, starts the close at edge r+BURST_LEN/2. This is the burst end (r+CL+BURST_LEN/2) minus CL, and the phase shows CLOSING after that edge.
- R7: If the open time is not met at that point, the automatic close starts at edge a+TRAS_CYC instead, where a is the edge of the open.
- R8: While an automatic close is pending, `pre_ok` is 0, and any read or close request is illegal.
- R9: An illegal request sets `violation` and changes no state. Illegal requests are: open with `act_ok` at 0, close with `pre_ok` at 0, a read outside ACTIVE or during a pending automatic close, and more than one request in the same cycle. `violation` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_act | input | 1 | Request to open a row in this bank |
| req_rd | input | 1 | Request for a plain read burst |
| req_rda | input | 1 | Request for a read burst with automatic close |
| req_pre | input | 1 | Request to close the open row |
| pre_ok | output | 1 | A close would be legal at the next edge |
| act_ok | output | 1 | An open would be legal at the next edge |
| bank_state | output | 2 | Phase: 0 idle, 1 row open, 2 closing |
| violation | output | 1 | Sticky flag for any illegal request |

## Verification
All outputs come from registers. A request sampled at edge E is therefore visible on `bank_state` and `violation` right after E, and `pre_ok`/`act_ok` follow the counters with no extra delay. The bench drives requests on falling edges and reads outputs on the next falling edge, so each expected value is tied to an exact edge count from the command. It probes the limit windows on both sides: one cycle before each flag must rise and the cycle it rises. It also places the automatic close at exactly r+BURST_LEN/2 or a+TRAS_CYC, computing each count from the picosecond parameters on its own.

// File: rtl/brg_pkg.sv
// Shared types and helpers for the bank row timing guard.
// Assumes: all time parameters are non-negative integers in picoseconds.
package brg_pkg;

    typedef enum logic [1:0] {
        BANK_IDLE   = 2'd0,
        BANK_ACTIVE = 2'd1,
        BANK_CLOSE  = 2'd2
    } bank_state_e;

    // Whole clock cycles covering a time span, rounded up.
    function automatic int unsigned span_to_cycles(input int unsigned span_ps,
                                                   input int unsigned tck_ps);
        return (span_ps + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/brg_cycle_timer.sv
// Down-counter that is loaded on start and reports done at zero.
// Assumes: LOAD is the number of edges after start before done rises.
module brg_cycle_timer #(
    parameter int unsigned LOAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(LOAD + 2);

    logic [W-1:0] cnt;

    // Load on start, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= W'(LOAD);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/brg_bank_ctrl.sv
// Phase machine for one bank: accepts legal requests, flags illegal
// ones and launches the automatic close.
// Assumes: timer done inputs come from brg_cycle_timer instances that
// are loaded by this module's start outputs.
module brg_bank_ctrl
    import brg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_act,
    input  logic        req_rd,
    input  logic        req_rda,
    input  logic        req_pre,
    input  logic        ras_done,
    input  logic        rp_done,
    input  logic        ap_done,
    output bank_state_e state,
    output logic        pre_ok,
    output logic        act_ok,
    output logic        violation,
    output logic        start_ras,
    output logic        start_rp,
    output logic        start_ap
);
    bank_state_e state_nx;
    logic        ap_pend;
    logic        rd_legal;
    logic        multi;
    logic        bad;
    logic        ap_fire;
    logic        go_act;
    logic        go_pre;

    // Legality of each request kind in the current cycle.
    always_comb begin
        multi    = ($countones({req_act, req_rd, req_rda, req_pre}) > 1);
        rd_legal = (state == BANK_ACTIVE) && !ap_pend;
        pre_ok   = (state == BANK_ACTIVE) && !ap_pend && ras_done;
        act_ok   = (state == BANK_IDLE) || ((state == BANK_CLOSE) && rp_done);
        bad      = multi || (req_act && !act_ok) || (req_pre && !pre_ok)
                   || ((req_rd || req_rda) && !rd_legal);
        go_act   = req_act && !bad;
        go_pre   = req_pre && !bad;
        start_ap = req_rda && !bad;
        ap_fire  = (state == BANK_ACTIVE) && ap_pend && ap_done && ras_done;
        start_ras = go_act;
        start_rp  = go_pre || ap_fire;
    end

    // Next phase from accepted requests and the automatic close.
    always_comb begin
        state_nx = state;
        case (state)
            BANK_IDLE:   if (go_act) state_nx = BANK_ACTIVE;
            BANK_ACTIVE: if (go_pre || ap_fire) state_nx = BANK_CLOSE;
            BANK_CLOSE: begin
                if (go_act)       state_nx = BANK_ACTIVE;
                else if (rp_done) state_nx = BANK_IDLE;
            end
            default:     state_nx = BANK_IDLE;
        endcase
    end

    // Phase, pending automatic close and sticky violation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BANK_IDLE;
            ap_pend   <= 1'b0;
            violation <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_ap)     ap_pend <= 1'b1;
            else if (ap_fire) ap_pend <= 1'b0;
            if (bad)          violation <= 1'b1;
        end
    end

    AST_OPEN_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BANK_ACTIVE && $past(state) == BANK_CLOSE) |-> $past(rp_done)); // R3
    AST_CLOSE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BANK_CLOSE && $past(state) == BANK_ACTIVE) |-> $past(ras_done)); // R4
    AST_NO_CLOSE_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ap_pend |-> !pre_ok); // R8
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_ok && act_ok)); // R1

endmodule

// File: rtl/bank_row_guard.sv
// Top of the bank row timing guard: converts the picosecond limits to
// cycle counts, and wires three timers to the phase machine.
// Assumes: BURST_LEN is even and at least 2, TCK_PS is non-zero.
module bank_row_guard
    import brg_pkg::*;
#(
    parameter int unsigned TCK_PS    = 5000,
    parameter int unsigned TRAS_PS   = 42000,
    parameter int unsigned TRP_PS    = 18000,
    parameter int unsigned CAS_LAT   = 3,
    parameter int unsigned BURST_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_act,
    input  logic       req_rd,
    input  logic       req_rda,
    input  logic       req_pre,
    output logic       pre_ok,
    output logic       act_ok,
    output logic [1:0] bank_state,
    output logic       violation
);
    localparam int unsigned TRAS_CYC  = span_to_cycles(TRAS_PS, TCK_PS);
    localparam int unsigned TRP_CYC   = span_to_cycles(TRP_PS, TCK_PS);
    localparam int unsigned BURST_CYC = BURST_LEN / 2;
    // Automatic close point: burst end (CL + burst) minus CL.
    localparam int unsigned AP_OFFSET = (CAS_LAT + BURST_CYC) - CAS_LAT;
    localparam int unsigned RAS_LOAD  = (TRAS_CYC > 1) ? TRAS_CYC - 1 : 0;
    localparam int unsigned RP_LOAD   = (TRP_CYC > 1) ? TRP_CYC - 1 : 0;
    localparam int unsigned AP_LOAD   = (AP_OFFSET > 1) ? AP_OFFSET - 1 : 0;

    bank_state_e state;
    logic ras_done, rp_done, ap_done;
    logic start_ras, start_rp, start_ap;

    brg_cycle_timer #(.LOAD(RAS_LOAD)) u_ras (
        .clk(clk), .rst_n(rst_n), .start(start_ras), .done(ras_done));

    brg_cycle_timer #(.LOAD(RP_LOAD)) u_rp (
        .clk(clk), .rst_n(rst_n), .start(start_rp), .done(rp_done));

    brg_cycle_timer #(.LOAD(AP_LOAD)) u_ap (
        .clk(clk), .rst_n(rst_n), .start(start_ap), .done(ap_done));

    brg_bank_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_act(req_act), .req_rd(req_rd), .req_rda(req_rda), .req_pre(req_pre),
        .ras_done(ras_done), .rp_done(rp_done), .ap_done(ap_done),
        .state(state), .pre_ok(pre_ok), .act_ok(act_ok), .violation(violation),
        .start_ras(start_ras), .start_rp(start_rp), .start_ap(start_ap));

    assign bank_state = state;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (bank_state == 2'd0 && !violation)); // R1
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bank_state != 2'd3); // R1

endmodule

// File: tb/sim_bank_row_guard.sv
module sim_bank_row_guard;
    localparam int unsigned TCK_PS = 5000;
    localparam int unsigned TRAS_PS = 42000;
    localparam int unsigned TRP_PS = 18000;
    localparam int unsigned BL = 8;
    localparam int TRAS = int'((TRAS_PS + TCK_PS - 1) / TCK_PS);
    localparam int TRP  = int'((TRP_PS + TCK_PS - 1) / TCK_PS);
    localparam int BURST = int'(BL / 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_act = 0, req_rd = 0, req_rda = 0, req_pre = 0;
    logic pre_ok, act_ok, violation;
    logic [1:0] bank_state;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_row_guard #(.TCK_PS(TCK_PS), .TRAS_PS(TRAS_PS), .TRP_PS(TRP_PS),
                     .CAS_LAT(3), .BURST_LEN(BL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_act(req_act), .req_rd(req_rd),
        .req_rda(req_rda), .req_pre(req_pre), .pre_ok(pre_ok), .act_ok(act_ok),
        .bank_state(bank_state), .violation(violation));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a request vector {act,rd,rda,pre} for one edge.
    task automatic cmd(input logic [3:0] v);
        {req_act, req_rd, req_rda, req_pre} = v;
        @(negedge clk);
        {req_act, req_rd, req_rda, req_pre} = 4'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        wait_cyc(2);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", bank_state, 0);
        check("R1 act_ok", act_ok, 1);
        check("R1 pre_ok", pre_ok, 0);
        check("R1 violation", violation, 0);
    endtask

    task automatic t_ras_rp();
        do_reset();
        check("R2 cycle counts", TRAS * 100 + TRP, 904);
        cmd(4'b1000);
        check("R4 state open", bank_state, 1);
        wait_cyc(TRAS - 2);
        check("R4 pre_ok early", pre_ok, 0);
        wait_cyc(1);
        check("R4 pre_ok at limit", pre_ok, 1);
        cmd(4'b0001);
        check("R3 closing", bank_state, 2);
        wait_cyc(TRP - 2);
        check("R3 act_ok early", act_ok, 0);
        wait_cyc(1);
        check("R3 act_ok at limit", act_ok, 1);
        cmd(4'b1000);
        check("R3 reopen state", bank_state, 1);
        check("R3 reopen no violation", violation, 0);
    endtask

    task automatic t_rp_to_idle();
        do_reset();
        cmd(4'b1000);
        wait_cyc(TRAS - 1);
        cmd(4'b0001);
        wait_cyc(TRP - 1);
        check("R3 still closing", bank_state, 2);
        wait_cyc(1);
        check("R3 idle after close", bank_state, 0);
    endtask

    task automatic t_early_close();
        do_reset();
        cmd(4'b1000);
        wait_cyc(1);
        cmd(4'b0001);
        check("R9 early close flagged", violation, 1);
        check("R9 early close ignored", bank_state, 1);
        wait_cyc(3);
        check("R9 sticky", violation, 1);
    endtask

    task automatic t_interrupt_read();
        do_reset();
        cmd(4'b1000);
        wait_cyc(TRAS);
        cmd(4'b0100);
        check("R5 pre_ok after read", pre_ok, 1);
        cmd(4'b0001);
        check("R5 interrupting close", bank_state, 2);
        check("R5 no violation", violation, 0);
    endtask

    task automatic t_auto_late();
        do_reset();
        cmd(4'b1000);
        wait_cyc(TRAS);
        cmd(4'b0010);
        check("R8 pre_ok pending", pre_ok, 0);
        wait_cyc(BURST - 1);
        check("R6 before auto close", bank_state, 1);
        wait_cyc(1);
        check("R6 auto close at burst end minus CL", bank_state, 2);
        wait_cyc(TRP);
        check("R6 idle after auto close", bank_state, 0);
        check("R6 no violation", violation, 0);
    endtask

    task automatic t_auto_early();
        do_reset();
        cmd(4'b1000);
        cmd(4'b0010);
        wait_cyc(TRAS - 2);
        check("R7 held by open time", bank_state, 1);
        wait_cyc(1);
        check("R7 close at open limit", bank_state, 2);
        check("R7 no violation", violation, 0);
    endtask

    task automatic t_pending_read();
        do_reset();
        cmd(4'b1000);
        wait_cyc(TRAS);
        cmd(4'b0010);
        cmd(4'b0100);
        check("R8 read during pending", violation, 1);
        check("R8 state kept", bank_state, 1);
    endtask

    task automatic t_bad_open_and_multi();
        do_reset();
        cmd(4'b1000);
        cmd(4'b1000);
        check("R9 open while open", violation, 1);
        check("R9 open while open state", bank_state, 1);
        do_reset();
        cmd(4'b1001);
        check("R9 multi request", violation, 1);
        check("R9 multi ignored", bank_state, 0);
        do_reset();
        cmd(4'b0100);
        check("R9 read while idle", violation, 1);
        do_reset();
        cmd(4'b1000);
        wait_cyc(TRAS - 1);
        cmd(4'b0001);
        cmd(4'b1000);
        check("R3 open too soon flagged", violation, 1);
        check("R3 open too soon ignored", bank_state, 2);
    endtask

    initial begin
        wait_cyc(20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ras_rp();
        t_rp_to_idle();
        t_early_close();
        t_interrupt_read();
        t_auto_late();
        t_auto_early();
        t_pending_read();
        t_bad_open_and_multi();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule